// File: doc/BRIEF.md
# S/PDIF Receiver Status and Control Registers

This block is the register front end of a digital audio receiver. A decoder feeds it one-cycle event strobes once per frame: sample validity, a non-audio preamble, loss of input stream, a biphase coding error, a parity error, PLL lock, and channel-status bytes. The block turns these into a status word that software reads over a small register bus. Most error flags are sticky and are cleared by the act of reading the status word. A control word sets the output mute, picks the receiver clock source, holds the receiver in reset, and turns on a long hold window for non-audio detection.

The non-audio flag has two modes. In the plain mode it follows the preamble strobe at each frame start. In the extended mode it is set by a preamble and stays set until a full window of frame starts passes with no new preamble. Each edge of this flag can raise an interrupt pulse, and software can enable the rising and falling edges on their own. The serial data outputs pass through a gate that sends zeros while muted or in reset. The bit and frame clocks always pass through unchanged.

Top module: `spdif_rx_ctrl`

## Requirements
- R1: After reset the control word and the status word read as zero, rx_en_o and pll_en_o are 1, clk_ext_sel_o and na_irq_o are 0, and sdata_o equals sdata_i.
- R2: Address 0 is the control word: bit 0 mute, bit 1 external clock select, bit 2 receiver reset, bit 3 extended non-audio enable, bit 4 rising-edge interrupt enable, bit 5 falling-edge interrupt enable. Bits 6 and up read as zero and ignore writes. Writes to address 1 (status) are ignored. bus_rdata is updated on the clock edge at which bus_rd_en is sampled high.
- R3: Address 1 is the status word: bit 0 validity, bit 1 non-audio, bit 2 no-stream, bit 3 biphase error, bit 4 parity error, bit 5 lock, and bits 15:8 hold the last channel-status byte taken with cs_idx equal to 0. Bytes with any other index leave bits 15:8 unchanged.
- R4: The validity, no-stream, biphase-error, parity-error and lock flags set on their strobe and stay set until a read of address 1. That read returns them set and then clears them. A read of address 0 leaves them unchanged.
- R5: A strobe in the same cycle as a status read wins: the flag is set after the read.
- R6: When extended mode is not active, the non-audio flag takes the value of na_pre_stb at each cycle where frame_stb is high. A preamble with no frame strobe has no effect.
- R7: Extended mode is active when control bit 3 is 1 and bit 1 is 0. In this mode a preamble sets the flag and restarts the frame count. The flag clears on the WINDOW-th frame strobe (default 4096) that arrives with no preamble in between.
- R8: With bit 1 set, control bit 3 has no effect and the non-audio flag behaves as in R6.
- R9: na_irq_o is high for exactly the one cycle after the clock edge where the non-audio flag rises (if bit 4 is set) or falls (if bit 5 is set).
- R10: With mute set, sdata_o is zero, while bclk_o and fclk_o still follow bclk_i and fclk_i.
- R11: clk_ext_sel_o equals control bit 1. rx_en_o is the inverse of bit 2. pll_en_o is high only when bits 1 and 2 are both zero.
- R12: While bit 2 is set, sdata_o is zero, all event strobes and channel-status bytes are ignored, and the non-audio flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| frame_stb | input | 1 | Frame start strobe |
| na_pre_stb | input | 1 | Non-audio preamble seen |
| ev_validity | input | 1 | Validity bit event |
| ev_nostream | input | 1 | Input stream lost |
| ev_biph_err | input | 1 | Biphase coding error |
| ev_par_err | input | 1 | Parity error |
| ev_lock | input | 1 | PLL lock event |
| cs_vld | input | 1 | Channel-status byte valid |
| cs_idx | input | CSI_W | Index of the channel-status byte |
| cs_byte | input | 8 | Channel-status byte |
| sdata_i | input | LANES | Decoded serial data in |
| bclk_i | input | 1 | Bit clock in |
| fclk_i | input | 1 | Frame clock in |
| sdata_o | output | LANES | Gated serial data out |
| bclk_o | output | 1 | Bit clock out |
| fclk_o | output | 1 | Frame clock out |
| clk_ext_sel_o | output | 1 | Select external clock source |
| pll_en_o | output | 1 | Enable internal digital PLL |
| rx_en_o | output | 1 | Receiver enable |
| na_irq_o | output | 1 | Non-audio edge interrupt pulse |

## Verification
The assertions assume that every event strobe, frame strobe and preamble strobe is synchronous to clk and lasts one cycle per occurrence. They also assume that a status read marks the edge at which sticky flags may drop. The bench drives all strobes for exactly one cycle and changes them on the falling edge. It never issues a read and a write in the same cycle. In the plain non-audio mode it always pairs a preamble with a frame strobe, except in the one case that checks a preamble alone is ignored.

// File: rtl/spdif_rx_pkg.sv
package spdif_rx_pkg;
   // control word bit positions
   localparam int CTL_MUTE      = 0;
   localparam int CTL_EXTCLK    = 1;
   localparam int CTL_RXRST     = 2;
   localparam int CTL_NAEXT     = 3;
   localparam int CTL_IRQ_RISE  = 4;
   localparam int CTL_IRQ_FALL  = 5;
   localparam int CTL_BITS      = 6;

   // status word bit positions
   localparam int ST_VALID      = 0;
   localparam int ST_NONAUDIO   = 1;
   localparam int ST_NOSTREAM   = 2;
   localparam int ST_BIPH       = 3;
   localparam int ST_PARITY     = 4;
   localparam int ST_LOCK       = 5;
   localparam int ST_CS_LSB     = 8;

   // sticky event vector order
   localparam int SK_VALID      = 0;
   localparam int SK_NOSTREAM   = 1;
   localparam int SK_BIPH       = 2;
   localparam int SK_PARITY     = 3;
   localparam int SK_LOCK       = 4;
   localparam int SK_COUNT      = 5;

   localparam int ADDR_CTRL     = 0;
   localparam int ADDR_STAT     = 1;

   typedef struct packed {
      logic irq_fall_en;
      logic irq_rise_en;
      logic na_ext_en;
      logic rx_rst;
      logic ext_clk;
      logic mute;
   } ctl_t;
endpackage

// File: rtl/spdif_rx_ctl_reg.sv
module spdif_rx_ctl_reg
   import spdif_rx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output ctl_t              ctl,
   output logic [DATA_W-1:0] ctl_word
);
   localparam int PAD_W = DATA_W - CTL_BITS;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("spdif_rx_ctl_reg: DATA_W too small for control word");
      end
   endgenerate

   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q <= ctl_t'(wdata[CTL_BITS-1:0]);
      end
   end

   assign ctl      = ctl_q;
   assign ctl_word = {{PAD_W{1'b0}}, ctl_q};
endmodule

// File: rtl/spdif_rx_sticky.sv
module spdif_rx_sticky #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("spdif_rx_sticky: N must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_r <= 1'b0;
            end else if (set[i]) begin
               q_r <= 1'b1;
            end else if (clr) begin
               q_r <= 1'b0;
            end
         end
         assign q[i] = q_r;
      end
   endgenerate
endmodule

// File: rtl/spdif_rx_nonaudio.sv
module spdif_rx_nonaudio #(
   parameter int WINDOW = 4096,
   localparam int CW    = $clog2(WINDOW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          ext_mode,
   input  logic          frame_stb,
   input  logic          pre_stb,
   input  logic          rise_en,
   input  logic          fall_en,
   output logic          flag,
   output logic [CW-1:0] cnt,
   output logic          irq
);
   localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);
   localparam logic [CW-1:0] FULL = CW'(WINDOW);

   generate
      if (WINDOW < 2) begin : g_bad_window
         $error("spdif_rx_nonaudio: WINDOW must be at least 2");
      end
   endgenerate

   logic          flag_q;
   logic          flag_d;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         flag_d <= 1'b0;
         cnt_q  <= '0;
      end else begin
         flag_d <= flag_q;
         if (!enable) begin
            flag_q <= 1'b0;
            cnt_q  <= '0;
         end else if (ext_mode) begin
            if (pre_stb) begin
               flag_q <= 1'b1;
               cnt_q  <= '0;
            end else if (frame_stb && flag_q) begin
               if (cnt_q == LAST) begin
                  flag_q <= 1'b0;
               end
               if (cnt_q != FULL) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end else begin
            cnt_q <= '0;
            if (frame_stb) begin
               flag_q <= pre_stb;
            end
         end
      end
   end

   assign flag = flag_q;
   assign cnt  = cnt_q;
   assign irq  = (flag_q & ~flag_d & rise_en) | (~flag_q & flag_d & fall_en);
endmodule

// File: rtl/spdif_rx_ctrl.sv
module spdif_rx_ctrl
   import spdif_rx_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2,
   parameter int LANES    = 1,
   parameter int WINDOW   = 4096,
   parameter int CS_BYTES = 5,
   localparam int CSI_W   = $clog2(CS_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              frame_stb,
   input  logic              na_pre_stb,
   input  logic              ev_validity,
   input  logic              ev_nostream,
   input  logic              ev_biph_err,
   input  logic              ev_par_err,
   input  logic              ev_lock,
   input  logic              cs_vld,
   input  logic [CSI_W-1:0]  cs_idx,
   input  logic [7:0]        cs_byte,
   input  logic [LANES-1:0]  sdata_i,
   input  logic              bclk_i,
   input  logic              fclk_i,
   output logic [LANES-1:0]  sdata_o,
   output logic              bclk_o,
   output logic              fclk_o,
   output logic              clk_ext_sel_o,
   output logic              pll_en_o,
   output logic              rx_en_o,
   output logic              na_irq_o
);
   localparam int CNT_W = $clog2(WINDOW + 1);

   generate
      if (DATA_W < ST_CS_LSB + 8) begin : g_bad_data_w
         $error("spdif_rx_ctrl: DATA_W must hold the channel-status byte");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("spdif_rx_ctrl: ADDR_W must be positive");
      end
      if (CS_BYTES < 2) begin : g_bad_cs
         $error("spdif_rx_ctrl: CS_BYTES must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("spdif_rx_ctrl: LANES must be positive");
      end
   endgenerate

   // ---------------- bus decode ----------------
   logic sel_ctrl;
   logic sel_stat;
   logic ctl_wr;
   logic rd_clr;

   assign sel_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
   assign sel_stat = (bus_addr == ADDR_W'(ADDR_STAT));
   assign ctl_wr   = bus_wr_en & sel_ctrl;
   assign rd_clr   = bus_rd_en & sel_stat;

   // ---------------- control ----------------
   ctl_t              ctl;
   logic [DATA_W-1:0] ctl_word;

   spdif_rx_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctl_wr),
      .wdata    (bus_wdata),
      .ctl      (ctl),
      .ctl_word (ctl_word)
   );

   logic rx_active;
   logic ext_act;

   assign rx_active = ~ctl.rx_rst;
   assign ext_act   = ctl.na_ext_en & ~ctl.ext_clk;

   // ---------------- sticky flags ----------------
   logic [SK_COUNT-1:0] ev_raw;
   logic [SK_COUNT-1:0] ev_set;
   logic [SK_COUNT-1:0] sticky;

   always_comb begin
      ev_raw              = '0;
      ev_raw[SK_VALID]    = ev_validity;
      ev_raw[SK_NOSTREAM] = ev_nostream;
      ev_raw[SK_BIPH]     = ev_biph_err;
      ev_raw[SK_PARITY]   = ev_par_err;
      ev_raw[SK_LOCK]     = ev_lock;
   end

   assign ev_set = ev_raw & {SK_COUNT{rx_active}};

   spdif_rx_sticky #(.N(SK_COUNT)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_set),
      .clr   (rd_clr),
      .q     (sticky)
   );

   // ---------------- non-audio detector ----------------
   logic             na_flag;
   logic [CNT_W-1:0] na_cnt;

   spdif_rx_nonaudio #(.WINDOW(WINDOW)) u_na (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (rx_active),
      .ext_mode  (ext_act),
      .frame_stb (frame_stb),
      .pre_stb   (na_pre_stb),
      .rise_en   (ctl.irq_rise_en),
      .fall_en   (ctl.irq_fall_en),
      .flag      (na_flag),
      .cnt       (na_cnt),
      .irq       (na_irq_o)
   );

   // ---------------- channel-status low byte ----------------
   logic [7:0] cs_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_low <= '0;
      end else if (rx_active && cs_vld && (cs_idx == '0)) begin
         cs_low <= cs_byte;
      end
   end

   // ---------------- status word and read port ----------------
   logic [DATA_W-1:0] stat_word;

   always_comb begin
      stat_word                          = '0;
      stat_word[ST_VALID]                = sticky[SK_VALID];
      stat_word[ST_NONAUDIO]             = na_flag;
      stat_word[ST_NOSTREAM]             = sticky[SK_NOSTREAM];
      stat_word[ST_BIPH]                 = sticky[SK_BIPH];
      stat_word[ST_PARITY]               = sticky[SK_PARITY];
      stat_word[ST_LOCK]                 = sticky[SK_LOCK];
      stat_word[ST_CS_LSB +: 8]          = cs_low;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd_en) begin
         if (sel_stat) begin
            bus_rdata <= stat_word;
         end else if (sel_ctrl) begin
            bus_rdata <= ctl_word;
         end else begin
            bus_rdata <= '0;
         end
      end
   end

   // ---------------- output gating ----------------
   logic data_block;

   assign data_block = ctl.mute | ctl.rx_rst;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign sdata_o[l] = sdata_i[l] & ~data_block;
      end
   endgenerate

   assign bclk_o        = bclk_i;
   assign fclk_o        = fclk_i;
   assign clk_ext_sel_o = ctl.ext_clk;
   assign rx_en_o       = rx_active;
   assign pll_en_o      = rx_active & ~ctl.ext_clk;
endmodule

// File: rtl/spdif_rx_ctrl_chk.sv
module spdif_rx_ctrl_chk #(
   parameter int WINDOW = 4096,
   parameter int LANES  = 1,
   localparam int CW    = $clog2(WINDOW + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_clr,
   input logic [4:0]       sticky,
   input logic [4:0]       ev_set,
   input logic             mute,
   input logic             ext_clk,
   input logic             rx_rst,
   input logic             ext_act,
   input logic             frame_stb,
   input logic             na_flag,
   input logic [CW-1:0]    na_cnt,
   input logic             na_irq,
   input logic             pll_en,
   input logic [LANES-1:0] sdata_o
);
   localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> ((sticky & $past(sticky)) == $past(sticky)));

   // R5
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_set) |=> ((sticky & $past(ev_set)) == $past(ev_set)));

   // R10
   mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mute |-> (sdata_o == '0));

   // R11
   pll_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |-> (!ext_clk && !rx_rst));

   // R9
   irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      na_irq |-> (na_flag != $past(na_flag)));

   // R7
   window_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ext_act) && !$past(rx_rst) && $past(na_flag) && !na_flag)
      |-> ($past(frame_stb) && ($past(na_cnt) == LAST)));
endmodule

bind spdif_rx_ctrl spdif_rx_ctrl_chk #(.WINDOW(WINDOW), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_clr    (rd_clr),
   .sticky    (sticky),
   .ev_set    (ev_set),
   .mute      (ctl.mute),
   .ext_clk   (ctl.ext_clk),
   .rx_rst    (ctl.rx_rst),
   .ext_act   (ext_act),
   .frame_stb (frame_stb),
   .na_flag   (na_flag),
   .na_cnt    (na_cnt),
   .na_irq    (na_irq_o),
   .pll_en    (pll_en_o),
   .sdata_o   (sdata_o)
);

// File: tb/spdif_rx_ctrl_test.sv
module spdif_rx_ctrl_test;
   localparam int DATA_W   = 16;
   localparam int ADDR_W   = 2;
   localparam int LANES    = 1;
   localparam int WINDOW   = 4096;
   localparam int CS_BYTES = 5;
   localparam int CSI_W    = $clog2(CS_BYTES);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr_en = 1'b0;
   logic              bus_rd_en = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              frame_stb = 1'b0;
   logic              na_pre_stb = 1'b0;
   logic              ev_validity = 1'b0;
   logic              ev_nostream = 1'b0;
   logic              ev_biph_err = 1'b0;
   logic              ev_par_err = 1'b0;
   logic              ev_lock = 1'b0;
   logic              cs_vld = 1'b0;
   logic [CSI_W-1:0]  cs_idx = '0;
   logic [7:0]        cs_byte = '0;
   logic [LANES-1:0]  sdata_i = '1;
   logic              bclk_i = 1'b0;
   logic              fclk_i = 1'b0;
   logic [LANES-1:0]  sdata_o;
   logic              bclk_o;
   logic              fclk_o;
   logic              clk_ext_sel_o;
   logic              pll_en_o;
   logic              rx_en_o;
   logic              na_irq_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   spdif_rx_ctrl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES),
      .WINDOW(WINDOW), .CS_BYTES(CS_BYTES)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .frame_stb(frame_stb), .na_pre_stb(na_pre_stb),
      .ev_validity(ev_validity), .ev_nostream(ev_nostream),
      .ev_biph_err(ev_biph_err), .ev_par_err(ev_par_err), .ev_lock(ev_lock),
      .cs_vld(cs_vld), .cs_idx(cs_idx), .cs_byte(cs_byte),
      .sdata_i(sdata_i), .bclk_i(bclk_i), .fclk_i(fclk_i),
      .sdata_o(sdata_o), .bclk_o(bclk_o), .fclk_o(fclk_o),
      .clk_ext_sel_o(clk_ext_sel_o), .pll_en_o(pll_en_o),
      .rx_en_o(rx_en_o), .na_irq_o(na_irq_o)
   );

   // vector: {req[3:0], rd, wr, addr, ev[4:0]={lock,par,biph,nostream,validity}, wdata[15:0], exp[15:0]}
   localparam int VW = 44;
   function automatic logic [VW-1:0] mk(input int req, input bit rd, input bit wr,
                                        input bit addr, input logic [4:0] ev,
                                        input logic [15:0] wd, input logic [15:0] ex);
      return {4'(req), rd, wr, addr, ev, wd, ex};
   endfunction

   localparam int NV = 30;
   localparam logic [VW-1:0] TBL [NV] = '{
      mk(1,  1, 0, 1, 5'b00000, 16'h0000, 16'h0000),
      mk(1,  1, 0, 0, 5'b00000, 16'h0000, 16'h0000),
      mk(2,  0, 1, 0, 5'b00000, 16'hFFFF, 16'h0000),
      mk(2,  1, 0, 0, 5'b00000, 16'h0000, 16'h003F),
      mk(2,  0, 1, 0, 5'b00000, 16'h0000, 16'h0000),
      mk(2,  1, 0, 0, 5'b00000, 16'h0000, 16'h0000),
      mk(4,  0, 0, 0, 5'b00001, 16'h0000, 16'h0000),
      mk(4,  1, 0, 1, 5'b00000, 16'h0000, 16'h0001),
      mk(4,  1, 0, 1, 5'b00000, 16'h0000, 16'h0000),
      mk(4,  0, 0, 0, 5'b01100, 16'h0000, 16'h0000),
      mk(4,  0, 0, 0, 5'b00100, 16'h0000, 16'h0000),
      mk(4,  1, 0, 1, 5'b00000, 16'h0000, 16'h0018),
      mk(5,  0, 0, 0, 5'b10000, 16'h0000, 16'h0000),
      mk(5,  1, 0, 1, 5'b10000, 16'h0000, 16'h0020),
      mk(5,  1, 0, 1, 5'b00000, 16'h0000, 16'h0020),
      mk(5,  1, 0, 1, 5'b00000, 16'h0000, 16'h0000),
      mk(3,  0, 0, 0, 5'b00010, 16'h0000, 16'h0000),
      mk(3,  1, 0, 1, 5'b00000, 16'h0000, 16'h0004),
      mk(2,  0, 1, 1, 5'b00000, 16'hFFFF, 16'h0000),
      mk(2,  1, 0, 1, 5'b00000, 16'h0000, 16'h0000),
      mk(12, 0, 1, 0, 5'b00000, 16'h0004, 16'h0000),
      mk(12, 0, 0, 0, 5'b11111, 16'h0000, 16'h0000),
      mk(12, 0, 1, 0, 5'b00000, 16'h0000, 16'h0000),
      mk(12, 1, 0, 1, 5'b00000, 16'h0000, 16'h0000),
      mk(3,  0, 0, 0, 5'b11111, 16'h0000, 16'h0000),
      mk(3,  1, 0, 1, 5'b00000, 16'h0000, 16'h003D),
      mk(4,  1, 0, 1, 5'b00000, 16'h0000, 16'h0000),
      mk(4,  0, 0, 0, 5'b00001, 16'h0000, 16'h0000),
      mk(4,  1, 0, 0, 5'b00000, 16'h0000, 16'h0000),
      mk(4,  1, 0, 1, 5'b00000, 16'h0000, 16'h0001)
   };

   function automatic string rtag(input int n);
      case (n)
         1:  return "R1";
         2:  return "R2";
         3:  return "R3";
         4:  return "R4";
         5:  return "R5";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // drive one cycle at the falling edge, then sample after the next rising edge
   task automatic cycle(input bit rd, input bit wr, input int addr,
                        input logic [4:0] ev, input logic [15:0] wd,
                        input bit fr, input bit pre);
      bus_rd_en   = rd;
      bus_wr_en   = wr;
      bus_addr    = ADDR_W'(addr);
      bus_wdata   = wd;
      ev_validity = ev[0];
      ev_nostream = ev[1];
      ev_biph_err = ev[2];
      ev_par_err  = ev[3];
      ev_lock     = ev[4];
      frame_stb   = fr;
      na_pre_stb  = pre;
      @(posedge clk);
      @(negedge clk);
      bus_rd_en   = 1'b0;
      bus_wr_en   = 1'b0;
      ev_validity = 1'b0;
      ev_nostream = 1'b0;
      ev_biph_err = 1'b0;
      ev_par_err  = 1'b0;
      ev_lock     = 1'b0;
      frame_stb   = 1'b0;
      na_pre_stb  = 1'b0;
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      cycle(0, 1, 0, 5'b0, v, 0, 0);
   endtask

   task automatic rd_stat();
      cycle(1, 0, 1, 5'b0, 16'h0, 0, 0);
   endtask

   task automatic frames(input int n);
      for (int i = 0; i < n; i++) cycle(0, 0, 0, 5'b0, 16'h0, 1, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 outputs during and after reset
      check("R1", {28'b0, rx_en_o, pll_en_o, clk_ext_sel_o, na_irq_o}, 32'hC);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'(sdata_o), 32'(sdata_i));

      // table walk: R1..R5, R12
      for (int v = 0; v < NV; v++) begin
         logic [VW-1:0] e;
         e = TBL[v];
         cycle(e[39], e[38], int'(e[37]), e[36:32], e[31:16], 0, 0);
         if (e[39]) check(rtag(int'(e[43:40])), 32'(bus_rdata), 32'(e[15:0]));
      end

      // R10 mute keeps clocks
      wr_ctl(16'h0001);
      check("R10", 32'(sdata_o), 32'h0);
      bclk_i = 1'b1; fclk_i = 1'b0; #1;
      check("R10", {30'b0, bclk_o, fclk_o}, 32'h2);
      bclk_i = 1'b0; fclk_i = 1'b1; #1;
      check("R10", {30'b0, bclk_o, fclk_o}, 32'h1);
      wr_ctl(16'h0000);
      check("R10", 32'(sdata_o), 32'(sdata_i));

      // R11 clock source and enables
      wr_ctl(16'h0002);
      check("R11", {29'b0, clk_ext_sel_o, pll_en_o, rx_en_o}, 32'h5);
      wr_ctl(16'h0004);
      check("R11", {29'b0, clk_ext_sel_o, pll_en_o, rx_en_o}, 32'h0);
      check("R12", 32'(sdata_o), 32'h0);
      wr_ctl(16'h0000);

      // R3 channel-status byte capture
      cs_vld = 1'b1; cs_idx = '0; cs_byte = 8'hA5;
      @(posedge clk); @(negedge clk);
      cs_idx = CSI_W'(2); cs_byte = 8'h3C;
      @(posedge clk); @(negedge clk);
      cs_vld = 1'b0;
      rd_stat();
      check("R3", 32'(bus_rdata), 32'hA500);

      // R6 plain non-audio mode
      cycle(0, 0, 0, 5'b0, 16'h0, 1, 1);
      rd_stat();
      check("R6", 32'(bus_rdata[1]), 32'h1);
      cycle(0, 0, 0, 5'b0, 16'h0, 1, 0);
      rd_stat();
      check("R6", 32'(bus_rdata[1]), 32'h0);
      cycle(0, 0, 0, 5'b0, 16'h0, 0, 1);
      rd_stat();
      check("R6", 32'(bus_rdata[1]), 32'h0);

      // R12 reset clears a held non-audio flag
      cycle(0, 0, 0, 5'b0, 16'h0, 1, 1);
      wr_ctl(16'h0004);
      wr_ctl(16'h0000);
      rd_stat();
      check("R12", 32'(bus_rdata[1]), 32'h0);

      // R7 / R9 extended window with both interrupt edges
      wr_ctl(16'h0038);
      cycle(0, 0, 0, 5'b0, 16'h0, 1, 1);
      check("R9", 32'(na_irq_o), 32'h1);
      cycle(0, 0, 0, 5'b0, 16'h0, 0, 0);
      check("R9", 32'(na_irq_o), 32'h0);
      frames(WINDOW - 2);
      cycle(0, 0, 0, 5'b0, 16'h0, 0, 1);   // retrigger with no frame strobe
      frames(WINDOW - 1);
      rd_stat();
      check("R7", 32'(bus_rdata[1]), 32'h1);
      check("R9", 32'(na_irq_o), 32'h0);
      frames(1);
      check("R9", 32'(na_irq_o), 32'h1);
      rd_stat();
      check("R7", 32'(bus_rdata[1]), 32'h0);

      // R9 rising edge masked
      wr_ctl(16'h0028);
      cycle(0, 0, 0, 5'b0, 16'h0, 1, 1);
      check("R9", 32'(na_irq_o), 32'h0);
      rd_stat();
      check("R7", 32'(bus_rdata[1]), 32'h1);

      // R8 external clock forces plain mode
      wr_ctl(16'h000A);
      cycle(0, 0, 0, 5'b0, 16'h0, 1, 1);
      cycle(0, 0, 0, 5'b0, 16'h0, 1, 0);
      rd_stat();
      check("R8", 32'(bus_rdata[1]), 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule